// File: doc/BRIEF.md
# Multiplexed-Bus Memory Map Decoder

This block decodes the external address space of an 8-bit microcontroller whose data bus also carries the low address byte. While the address strobe is high, the block samples the shared bus into a low-address register on each clock edge. The high address byte arrives on its own dedicated lines. Those lines choose a single active-low chip select from five targets: program ROM, static RAM, a character LCD, an I/O register window and a spare expansion select.

The block also turns the E clock and the R/W line into separate active-low read and write strobes. Every select and every strobe is gated by E. The block contains the 8-bit output latch for the I/O window, which loads when the write strobe ends. It also contains the path that drives the input register onto the bus during a read of that window.

ROM occupies the upper half of the map. RAM occupies the lower half, apart from four 256-byte pages that are carved out of it. Page $10 is held back for on-chip registers and decodes to no select. Page $11 is the I/O window, page $12 is the spare select and page $14 is the LCD.

Top module: `mmap_decoder`

## Requirements
- R1: `rom_cs_n` is low exactly when E is high and A15 (bit 7 of `addr_hi`) is 1.
- R2: `ram_cs_n` is low exactly when E is high, A15 is 0, and `addr_hi` is none of $10, $11, $12 or $14.
- R3: `lcd_cs_n` is low exactly when E is high and `addr_hi` is $14.
- R4: `io_cs_n` is low exactly when E is high and `addr_hi` is $11. `sel0_cs_n` is low exactly when E is high and `addr_hi` is $12. Page $10 asserts no select.
- R5: At most one chip select is low at any time. When E is low, no select and no strobe is low.
- R6: `rd_n` is low exactly when E is high and R/W is 1. `wr_n` is low exactly when E is high and R/W is 0.
- R7: At every clock edge where `as` is high, `addr_lo` takes the value of `ad_in`. When `as` is low, `addr_lo` holds its value. Reset clears it to $00.
- R8: Reset clears `out_reg` to $00. After an I/O-window write, `out_reg` takes the bus data from the last clock edge of that write, at the first clock edge where the write is no longer active. `out_reg` does not change before that edge. Writes to other regions and all reads leave `out_reg` unchanged.
- R9: `ad_oe` is high exactly when E is high, R/W is 1 and `addr_hi` is $11. While it is high, `ad_out` equals `in_reg`. Otherwise `ad_out` is $00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than E |
| rst_n | input | 1 | Active-low asynchronous reset |
| e_clk | input | 1 | Bus E clock |
| rw | input | 1 | 1 = read, 0 = write |
| as | input | 1 | Address strobe, active high |
| addr_hi | input | 8 | High address lines A15..A8 |
| ad_in | input | 8 | Multiplexed address/data bus, input side |
| in_reg | input | 8 | Input register pins |
| ad_out | output | 8 | Data driven onto the bus |
| ad_oe | output | 1 | Bus output enable |
| addr_lo | output | 8 | Latched low address byte |
| out_reg | output | 8 | Output latch contents |
| rom_cs_n | output | 1 | ROM select |
| ram_cs_n | output | 1 | RAM select |
| lcd_cs_n | output | 1 | LCD select |
| io_cs_n | output | 1 | I/O window select |
| sel0_cs_n | output | 1 | Spare expansion select |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |

## Verification
The hardest case to reach is the output latch update. It depends on the write ending, and by then E is already low and every select is gone. A glitch or an early load is therefore not visible on any select. The stimulus holds an I/O write across a clock edge and checks that `out_reg` still holds its old value. It then drops E and checks the new value one edge later. It also repeats the same sequence on a RAM page to show that the latch stays unchanged. The decode itself is swept over all 256 high-address values with every combination of E and R/W.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_ROM  = 3'd1,
    RG_RAM  = 3'd2,
    RG_LCD  = 3'd3,
    RG_IO   = 3'd4,
    RG_SEL0 = 3'd5
  } region_t;

  // Fixed windows take priority over the RAM half; the top half is ROM.
  function automatic region_t decode_region(
    input logic [7:0] hi,
    input logic [7:0] rsv_page,
    input logic [7:0] io_page,
    input logic [7:0] sel0_page,
    input logic [7:0] lcd_page
  );
    region_t r;
    if (hi[7])                 r = RG_ROM;
    else if (hi == rsv_page)   r = RG_NONE;
    else if (hi == io_page)    r = RG_IO;
    else if (hi == sel0_page)  r = RG_SEL0;
    else if (hi == lcd_page)   r = RG_LCD;
    else                       r = RG_RAM;
    return r;
  endfunction

endpackage

// File: rtl/mmap_addr_latch.sv
module mmap_addr_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] addr_lo
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_lo <= '0;
    else if (as) addr_lo <= ad_in;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !as |=> $stable(addr_lo)) else $error("addr_lo moved without strobe"); // R7

endmodule

// File: rtl/mmap_bus_ctrl.sv
module mmap_bus_ctrl
  import mmap_pkg::*;
#(
  parameter logic [7:0] RSV_PAGE  = 8'h10,
  parameter logic [7:0] IO_PAGE   = 8'h11,
  parameter logic [7:0] SEL0_PAGE = 8'h12,
  parameter logic [7:0] LCD_PAGE  = 8'h14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       e_clk,
  input  logic       rw,
  input  logic [7:0] addr_hi,
  output logic       rom_cs_n,
  output logic       ram_cs_n,
  output logic       lcd_cs_n,
  output logic       io_cs_n,
  output logic       sel0_cs_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic       io_rd,
  output logic       io_wr
);

  region_t region;
  logic    rd_act, wr_act;

  always_comb region = decode_region(addr_hi, RSV_PAGE, IO_PAGE, SEL0_PAGE, LCD_PAGE);

  assign rd_act = e_clk &  rw;
  assign wr_act = e_clk & ~rw;

  assign rom_cs_n  = ~(e_clk && region == RG_ROM);
  assign ram_cs_n  = ~(e_clk && region == RG_RAM);
  assign lcd_cs_n  = ~(e_clk && region == RG_LCD);
  assign io_cs_n   = ~(e_clk && region == RG_IO);
  assign sel0_cs_n = ~(e_clk && region == RG_SEL0);
  assign rd_n      = ~rd_act;
  assign wr_n      = ~wr_act;

  assign io_rd = rd_act && region == RG_IO;
  assign io_wr = wr_act && region == RG_IO;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{rom_cs_n, ram_cs_n, lcd_cs_n, io_cs_n, sel0_cs_n})) else $error("two selects"); // R5
  AST_E_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !e_clk |-> (&{rom_cs_n, ram_cs_n, lcd_cs_n, io_cs_n, sel0_cs_n, rd_n, wr_n})) else $error("active with E low"); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)) else $error("read and write together"); // R6
  AST_ROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> addr_hi[7]) else $error("ROM below top half"); // R1
  AST_RAM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> !addr_hi[7]) else $error("RAM in top half"); // R2

endmodule

// File: rtl/mmap_io_port.sv
module mmap_io_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [DATA_W-1:0] in_reg,
  output logic [DATA_W-1:0] out_reg,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              wr_fall
);

  logic              io_wr_q;
  logic [DATA_W-1:0] data_q;

  assign wr_fall = io_wr_q & ~io_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_wr_q <= 1'b0;
      data_q  <= '0;
      out_reg <= '0;
    end else begin
      io_wr_q <= io_wr;
      if (io_wr)   data_q  <= ad_in;
      if (wr_fall) out_reg <= data_q;
    end
  end

  assign ad_oe  = io_rd;
  assign ad_out = ad_oe ? in_reg : '0;

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fall |=> $stable(out_reg)) else $error("latch moved outside write end"); // R8
  AST_NO_RD_DURING_WR: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> !ad_oe) else $error("bus driven during write"); // R9

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder #(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] RSV_PAGE  = 8'h10,
  parameter logic [7:0] IO_PAGE   = 8'h11,
  parameter logic [7:0] SEL0_PAGE = 8'h12,
  parameter logic [7:0] LCD_PAGE  = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_clk,
  input  logic              rw,
  input  logic              as,
  input  logic [7:0]        addr_hi,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [DATA_W-1:0] in_reg,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [DATA_W-1:0] addr_lo,
  output logic [DATA_W-1:0] out_reg,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              lcd_cs_n,
  output logic              io_cs_n,
  output logic              sel0_cs_n,
  output logic              rd_n,
  output logic              wr_n
);

  logic io_rd, io_wr, wr_fall;

  mmap_addr_latch #(.DATA_W(DATA_W)) u_alat (
    .clk(clk), .rst_n(rst_n), .as(as), .ad_in(ad_in), .addr_lo(addr_lo)
  );

  mmap_bus_ctrl #(
    .RSV_PAGE(RSV_PAGE), .IO_PAGE(IO_PAGE), .SEL0_PAGE(SEL0_PAGE), .LCD_PAGE(LCD_PAGE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .rw(rw), .addr_hi(addr_hi),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .lcd_cs_n(lcd_cs_n),
    .io_cs_n(io_cs_n), .sel0_cs_n(sel0_cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .io_rd(io_rd), .io_wr(io_wr)
  );

  mmap_io_port #(.DATA_W(DATA_W)) u_io (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .ad_in(ad_in),
    .in_reg(in_reg), .out_reg(out_reg), .ad_out(ad_out), .ad_oe(ad_oe),
    .wr_fall(wr_fall)
  );

  AST_OE_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!io_cs_n && !rd_n)) else $error("bus driven outside I/O read"); // R9
  AST_FALL_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |-> $past(!io_cs_n && !wr_n)) else $error("latch load without I/O write"); // R8

endmodule

// File: tb/test_mmap_decoder.sv
module test_mmap_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       e_clk = 1'b0, rw = 1'b1, as = 1'b0;
  logic [7:0] addr_hi = '0, ad_in = '0, in_reg = '0;
  logic [7:0] ad_out, addr_lo, out_reg;
  logic       ad_oe, rom_cs_n, ram_cs_n, lcd_cs_n, io_cs_n, sel0_cs_n, rd_n, wr_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmap_decoder i_mmap_decoder (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .rw(rw), .as(as), .addr_hi(addr_hi),
    .ad_in(ad_in), .in_reg(in_reg), .ad_out(ad_out), .ad_oe(ad_oe), .addr_lo(addr_lo),
    .out_reg(out_reg), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .lcd_cs_n(lcd_cs_n),
    .io_cs_n(io_cs_n), .sel0_cs_n(sel0_cs_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Write a byte with the given high address: one edge with write active, then E low.
  task automatic bus_write(input logic [7:0] hi, input logic [7:0] d);
    @(negedge clk); addr_hi = hi; rw = 1'b0; e_clk = 1'b1; ad_in = d;
    @(negedge clk); e_clk = 1'b0;
    @(negedge clk); rw = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset out_reg", out_reg, 8'h00);
    chk("R7 reset addr_lo", addr_lo, 8'h00);
    rst_n = 1'b1;

    // Full decode sweep
    for (int hi = 0; hi < 256; hi++) begin
      for (int m = 0; m < 4; m++) begin
        logic e, r, ram_pg;
        logic [6:0] exp_v, act_v;
        @(negedge clk);
        e = m[1]; r = m[0];
        addr_hi = hi[7:0]; e_clk = e; rw = r; in_reg = hi[7:0] ^ 8'h5A;
        #1;
        ram_pg = (hi < 128) && hi != 16 && hi != 17 && hi != 18 && hi != 20;
        exp_v = ~{e && hi >= 128, e && ram_pg, e && hi == 20, e && hi == 17,
                  e && hi == 18, e && r, e && !r};
        act_v = {rom_cs_n, ram_cs_n, lcd_cs_n, io_cs_n, sel0_cs_n, rd_n, wr_n};
        chk("R1 R2 R3 R4 R5 R6 decode", {hi[7:0], e, r, act_v}, {hi[7:0], e, r, exp_v});
        chk("R9 oe", ad_oe, e && r && hi == 17);
        chk("R9 ad_out", ad_out, (e && r && hi == 17) ? (hi[7:0] ^ 8'h5A) : 8'h00);
      end
    end
    @(negedge clk); e_clk = 1'b0; rw = 1'b1;
    chk("R8 sweep writes left latch alone", out_reg, 8'h00);

    // Low address capture
    foreach (ad_in[b]) begin
      logic [7:0] a;
      a = 8'h01 << b;
      @(negedge clk); as = 1'b1; ad_in = a;
      @(negedge clk); as = 1'b0; ad_in = ~a;
      chk("R7 capture", addr_lo, a);
      @(negedge clk);
      chk("R7 hold", addr_lo, a);
    end

    // Output latch timing
    @(negedge clk); addr_hi = 8'h11; rw = 1'b0; e_clk = 1'b1; ad_in = 8'hC3;
    @(negedge clk);
    chk("R8 no load while write active", out_reg, 8'h00);
    e_clk = 1'b0;
    @(negedge clk);
    chk("R8 load at write end", out_reg, 8'hC3);
    rw = 1'b1;

    bus_write(8'h20, 8'h3C);
    chk("R8 RAM write ignored", out_reg, 8'hC3);
    bus_write(8'h14, 8'h77);
    chk("R8 LCD write ignored", out_reg, 8'hC3);
    bus_write(8'h91, 8'h11);
    chk("R8 ROM write ignored", out_reg, 8'hC3);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = 8'h18 * (k + 1) + 8'h05;
      bus_write(8'h11, d);
      chk("R8 successive load", out_reg, d);
    end

    // I/O read does not disturb latch
    @(negedge clk); addr_hi = 8'h11; rw = 1'b1; e_clk = 1'b1; in_reg = 8'hA5; ad_in = 8'h00;
    #1;
    chk("R9 read drives input", ad_out, 8'hA5);
    @(negedge clk); e_clk = 1'b0;
    @(negedge clk);
    chk("R8 read left latch", out_reg, 8'h18 * 4 + 8'h05);
    chk("R9 released after read", ad_oe, 1'b0);

    finish_run();
  end
endmodule